// File: doc/BRIEF.md
# Single-Source Configurable-Trigger Interrupt Controller

This block watches one asynchronous interrupt line and turns it into one interrupt request toward a parent controller. The line is first brought into the clock domain through a two-flop synchronizer. A two-bit trigger selection then decides what counts as an event: a low level, a high level, a falling transition or a rising transition.

Each event sets a sticky pending flag. Software clears that flag by writing a one to it. A separate enable bit gates the pending flag onto the output, and the gated result is registered.

Software reaches the block over a plain 32-bit register port with write and read strobes and a word address. Three register placements are available and are fixed at build time. Edge sources are acknowledged before they are serviced, so a transition that arrives during service is not lost. Level sources are acknowledged after service, and the flag re-arms at once while the line stays active.

Top module: `trig_irq_ctl`

## Requirements
- R1: After reset the control word, the enable bit and the pending bit all read 0, and `irq_out` is 0. A control word of 0 selects level-low triggering with the source masked.
- R2: The control register sits at word address 0 in every layout and holds a full 32-bit word that reads back unchanged. Its bits [1:0] choose the trigger: 0 = level low, 1 = falling edge, 2 = level high, 3 = rising edge.
- R3: In a level trigger mode, pending is set on every cycle in which the synchronized line is at its active level. A clear written while the line is still active leaves pending reading 1 afterwards.
- R4: In an edge trigger mode, pending is set only by the selected transition of the synchronized line. The opposite transition and a steady level do not set it. A selected transition after a clear sets it again.
- R5: Pending is bit 0 of the pending register. Writing 1 to that bit clears it unless an event occurs in the same cycle. Writing 0 leaves it unchanged.
- R6: `irq_out` is the registered AND of pending and the enable bit, which is bit 0 of the enable register. Pending still latches while enable is 0. A line change becomes visible in pending on the 3rd rising clock edge after it, and in `irq_out` on the 4th.
- R7: `MAP` selects the word addresses of pending and enable. MAP_WIDE puts pending at 1 and enable at 13. MAP_PACKED (the default) puts pending at 1 and enable at 2. MAP_SWAPPED puts enable at 1 and pending at 2.
- R8: A read of a word address the layout does not map returns 0. A write to such an address changes no register.
- R9: Read data appears on `rdata` in the cycle after `rd_en` and is 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | 1 | Asynchronous interrupt line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The line is driven through every trigger mode: steady levels, each transition direction, and a transition that arrives after a clear. This separates level behaviour from edge behaviour and shows which transition each edge mode accepts. A clear is written while a level source is still active, and zero writes are made to the pending bit, to expose the set-versus-clear priority. One rising edge is timed cycle by cycle to pin down the synchronizer and output latency. Three instances, one per layout, show that each offset lands on the right register and that offsets a layout leaves unmapped read 0 and ignore writes.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LOW   = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HIGH  = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        MAP_WIDE    = 2'd0,
        MAP_PACKED  = 2'd1,
        MAP_SWAPPED = 2'd2
    } reg_map_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PEND,
        SEL_EN
    } reg_sel_e;

    typedef struct packed {
        logic now;
        logic prev;
    } line_samp_t;

    localparam logic [15:0] CTRL_WORD = 16'd0;

    function automatic logic [15:0] pend_word(reg_map_e m);
        case (m)
            MAP_SWAPPED: return 16'd2;
            default:     return 16'd1;
        endcase
    endfunction

    function automatic logic [15:0] en_word(reg_map_e m);
        case (m)
            MAP_WIDE:    return 16'd13;
            MAP_SWAPPED: return 16'd1;
            default:     return 16'd2;
        endcase
    endfunction

    function automatic reg_sel_e decode(reg_map_e m, logic [15:0] w);
        if (w == CTRL_WORD)    return SEL_CTRL;
        if (w == pend_word(m)) return SEL_PEND;
        if (w == en_word(m))   return SEL_EN;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/trig_irq_sync.sv
module trig_irq_sync
    import trig_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       d,
    output line_samp_t q
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[STAGES-1];
    end

    assign q.now  = chain[STAGES-1];
    assign q.prev = prev_q;
endmodule

// File: rtl/trig_irq_detect.sv
module trig_irq_detect
    import trig_irq_pkg::*;
(
    input  trig_mode_e mode,
    input  line_samp_t samp,
    output logic       evt
);
    always_comb begin
        case (mode)
            TRIG_LVL_LOW:   evt = ~samp.now;
            TRIG_LVL_HIGH:  evt = samp.now;
            TRIG_EDGE_FALL: evt = samp.prev & ~samp.now;
            TRIG_EDGE_RISE: evt = ~samp.prev & samp.now;
            default:        evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_irq_regs.sv
module trig_irq_regs
    import trig_irq_pkg::*;
#(
    parameter reg_map_e MAP    = MAP_PACKED,
    parameter int       DATA_W = 32,
    parameter int       ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt,
    output logic [DATA_W-1:0] rdata,
    output trig_mode_e        mode,
    output logic              en_q,
    output logic              pend_q
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rd_mux;
    logic              clr;

    assign sel  = decode(MAP, 16'(addr));
    assign clr  = wr_en && (sel == SEL_PEND) && wdata[0];
    assign mode = trig_mode_e'(ctrl_q[1:0]);

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_PEND: rd_mux[0] = pend_q;
            SEL_EN:   rd_mux[0] = en_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            rdata  <= '0;
        end else begin
            if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata;
            if (wr_en && sel == SEL_EN)   en_q   <= wdata[0];
            pend_q <= evt | (pend_q & ~clr);
            rdata  <= rd_en ? rd_mux : '0;
        end
    end

    // R5: a one written to pending with no competing event clears it
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !pend_q);

    // R3: an event always leaves pending set, even against a clear
    a_r3_event_wins: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend_q);

    // R4: pending only rises as a result of a detected event
    a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(evt));

    // R8: writes to unmapped words leave control and enable alone
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(en_q)));

    // R8: reads of unmapped words return zero
    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/trig_irq_ctl.sv
module trig_irq_ctl
    import trig_irq_pkg::*;
#(
    parameter reg_map_e MAP         = MAP_PACKED,
    parameter int       DATA_W      = 32,
    parameter int       ADDR_W      = 4,
    parameter int       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_line,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);
    line_samp_t samp;
    trig_mode_e mode;
    logic       evt;
    logic       en_q;
    logic       pend_q;

    trig_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_line),
        .q   (samp)
    );

    trig_irq_detect u_detect (
        .mode (mode),
        .samp (samp),
        .evt  (evt)
    );

    trig_irq_regs #(.MAP(MAP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .evt    (evt),
        .rdata  (rdata),
        .mode   (mode),
        .en_q   (en_q),
        .pend_q (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= pend_q & en_q;
    end

    // R6: a masked source keeps the output low on the next cycle
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !irq_out);

    // R6: the output is only high when pending was set a cycle before
    a_r6_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(pend_q));
endmodule

// File: tb/test_trig_irq_ctl.sv
module test_trig_irq_ctl;
    import trig_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  wr_en = '0;
    logic [2:0]  rd_en = '0;
    logic [31:0] rdata [3];
    logic        irq [3];
    logic        rd_seen = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        int          dut;
        string       req;
    } rd_item_t;
    rd_item_t sb_q [$];

    always #10 clk = ~clk;

    // 0: packed layout, 1: swapped layout, 2: wide layout
    trig_irq_ctl #(.MAP(MAP_PACKED)) i_trig_irq_ctl (
        .clk(clk), .rst(rst), .irq_line(line), .wr_en(wr_en[0]), .rd_en(rd_en[0]),
        .addr(addr), .wdata(wdata), .rdata(rdata[0]), .irq_out(irq[0]));
    trig_irq_ctl #(.MAP(MAP_SWAPPED)) i_trig_irq_ctl_swapped (
        .clk(clk), .rst(rst), .irq_line(line), .wr_en(wr_en[1]), .rd_en(rd_en[1]),
        .addr(addr), .wdata(wdata), .rdata(rdata[1]), .irq_out(irq[1]));
    trig_irq_ctl #(.MAP(MAP_WIDE)) i_trig_irq_ctl_wide (
        .clk(clk), .rst(rst), .irq_line(line), .wr_en(wr_en[2]), .rd_en(rd_en[2]),
        .addr(addr), .wdata(wdata), .rdata(rdata[2]), .irq_out(irq[2]));

    always @(posedge clk) rd_seen <= |rd_en;

    // Monitor: compare each read result against the queued expectation
    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rdata[it.dut] !== it.exp) begin
                errors++;
                $display("FAIL %s: dut%0d rdata got %h expected %h",
                         it.req, it.dut, rdata[it.dut], it.exp);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int d, logic [3:0] a, logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en[d] = 1'b1;
        @(negedge clk);
        wr_en[d] = 1'b0;
    endtask

    task automatic rd(int d, logic [3:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        addr = a; rd_en[d] = 1'b1;
        sb_q.push_back('{exp, d, req});
        @(negedge clk);
        rd_en[d] = 1'b0;
    endtask

    task automatic chk_irq(int d, logic exp, string req);
        checks++;
        if (irq[d] !== exp) begin
            errors++;
            $display("FAIL %s: dut%0d irq_out got %b expected %b", req, d, irq[d], exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk_irq(0, 1'b0, "R1");
        chk_irq(1, 1'b0, "R1");
        @(negedge clk) rst = 1'b0;
        rd(0, 4'd0, 32'h0, "R1 ctrl");
        rd(0, 4'd2, 32'h0, "R1 enable");
        rd(1, 4'd1, 32'h0, "R1 enable swapped");
        rd(0, 4'd5, 32'h0, "R9 idle read");

        // software init: mask, then clear pending
        wr(0, 4'd2, 32'h0);
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h0, "R5 init clear");
        chk_irq(0, 1'b0, "R5 init");

        // rising edge mode with spare bits kept
        wr(0, 4'd0, 32'hABCD_0003);
        rd(0, 4'd0, 32'hABCD_0003, "R2 readback");
        wr(0, 4'd2, 32'h1);
        line = 1'b0;
        cyc(6);
        chk_irq(0, 1'b0, "R4 falling ignored");
        rd(0, 4'd1, 32'h0, "R4 falling ignored");

        // exact latency of a rising edge
        @(negedge clk) line = 1'b1;
        cyc(3);
        chk_irq(0, 1'b0, "R6 latency early");
        cyc(1);
        chk_irq(0, 1'b1, "R6 latency");
        rd(0, 4'd1, 32'h1, "R4 rising sets");

        // acknowledge, steady high does not retrigger, new edge does
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h0, "R4 steady level");
        cyc(2);
        chk_irq(0, 1'b0, "R6 cleared");
        line = 1'b0; cyc(3);
        line = 1'b1; cyc(4);
        rd(0, 4'd1, 32'h1, "R4 edge after clear");

        // zero write keeps pending
        wr(0, 4'd1, 32'h0);
        rd(0, 4'd1, 32'h1, "R5 zero write");
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h0, "R5 one write");

        // falling edge mode
        wr(0, 4'd0, 32'h1);
        line = 1'b0; cyc(4);
        rd(0, 4'd1, 32'h1, "R2 falling code");
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h0, "R4 low level no retrigger");
        line = 1'b1; cyc(4);
        rd(0, 4'd1, 32'h0, "R4 rising ignored");

        // level high mode
        wr(0, 4'd0, 32'h2);
        cyc(2);
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h1, "R3 rearm while active");
        line = 1'b0; cyc(4);
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h0, "R3 inactive clears");
        cyc(3);
        rd(0, 4'd1, 32'h0, "R3 stays clear");

        // level low mode
        wr(0, 4'd0, 32'h0);
        cyc(2);
        rd(0, 4'd1, 32'h1, "R2 level low code");
        line = 1'b1; cyc(4);
        wr(0, 4'd1, 32'h1);
        rd(0, 4'd1, 32'h0, "R3 level low clears");

        // masking
        wr(0, 4'd2, 32'h0);
        wr(0, 4'd0, 32'h2);
        cyc(3);
        chk_irq(0, 1'b0, "R6 masked");
        rd(0, 4'd1, 32'h1, "R6 latches while masked");
        wr(0, 4'd2, 32'h1);
        cyc(1);
        chk_irq(0, 1'b1, "R6 unmask");
        wr(0, 4'd2, 32'h0);
        cyc(1);
        chk_irq(0, 1'b0, "R6 remask");

        // unmapped words
        rd(0, 4'd5, 32'h0, "R8 read unmapped");
        rd(0, 4'd13, 32'h0, "R8 read unmapped");
        wr(0, 4'd5, 32'hFFFF_FFFF);
        wr(0, 4'd13, 32'h1);
        rd(0, 4'd0, 32'h2, "R8 ctrl untouched");
        rd(0, 4'd2, 32'h0, "R8 enable untouched");
        chk_irq(0, 1'b0, "R8");

        // swapped layout
        wr(1, 4'd1, 32'h1);
        rd(1, 4'd1, 32'h1, "R7 swapped enable");
        rd(1, 4'd13, 32'h0, "R7 swapped unmapped");
        wr(1, 4'd2, 32'h1);
        rd(1, 4'd2, 32'h0, "R7 swapped pending");
        cyc(1);
        chk_irq(1, 1'b0, "R7 swapped");
        line = 1'b0; cyc(5);
        chk_irq(1, 1'b1, "R7 swapped irq");

        // wide layout
        wr(2, 4'd13, 32'h1);
        rd(2, 4'd13, 32'h1, "R7 wide enable");
        rd(2, 4'd1, 32'h1, "R7 wide pending");
        rd(2, 4'd2, 32'h0, "R7 wide unmapped");
        rd(2, 4'd0, 32'h0, "R7 wide ctrl");
        chk_irq(2, 1'b1, "R7 wide irq");

        cyc(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule